// File: doc/BRIEF.md
# Resettable Pixel Clock Divider with Symmetric Odd Ratios

This block turns a fast input clock into a slower pixel clock by dividing it by one of nine selectable ratios. Odd ratios keep a true half-and-half duty cycle because both edges of the fast clock are used. Between scan lines the pixel clock sits high. An external start pulse, which usually comes from a conditioned beam-detect signal, restarts the divider. The first pixel clock period then begins a fixed number of fast-clock edges after that pulse, so every line starts at the same phase relative to the fast clock.

The start input is asynchronous. It passes through a polarity selector and a synchronizer before its active edge is detected in the fast-clock domain. When the start input drops back to its inactive level, the divider finishes the pixel clock period it is in and parks with the output high. A modulus change takes effect only at a period boundary or at a restart, so a running output never gets a shortened or stretched period. A separate suppress control holds the output high whatever the divider is doing.

Top module: `pclk_divider`

## Requirements
- R1: The ratio code on `mod_sel` selects the division ratio N as follows: code 0 gives 3, code 1 gives 4, code 2 gives 5, code 3 gives 6, code 4 gives 8, code 5 gives 10, code 6 gives 12, code 7 gives 16 and code 8 gives 20.
- R2: Any ratio code from 9 to 15 divides by 4.
- R3: Each running pixel clock period lasts N fast-clock cycles. It is low for exactly N half-cycles and then high for exactly N half-cycles, for odd N as well as even N.
- R4: The fast-clock edges are numbered from E0, the first rising edge at which the start input is at its active level after an inactive stretch. `pclk` is still high after E1 and goes low at E2, whatever the ratio. The next stretch of at least one pixel period with the start input inactive arms the next restart.
- R5: After the start input returns to its inactive level, the current period completes with its full low and high phases. `pclk` then stays high and the divider stays idle until the next active edge.
- R6: When `en_pol` is 1 the start input is active high. When `en_pol` is 0 it is active low. Holding the input at its inactive level never starts the divider.
- R7: While `suppress` is 1, `pclk` is held high one fast-clock cycle after it is sampled, even while the divider runs.
- R8: A ratio code change takes effect at the next period boundary or restart. The period in progress keeps its old length.
- R9: While reset is applied and afterwards, `pclk` is high and the divider is idle until a start edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Asynchronous start/enable input (line-start pulse) |
| en_pol | input | 1 | Start input active level: 1 = high, 0 = low |
| mod_sel | input | 4 | Division ratio code |
| suppress | input | 1 | Holds the pixel clock high while set |
| pclk | output | 1 | Pixel clock output |

## Verification
The hardest situation to reach is a ratio change that lands in the middle of a running period. The new code has to reach the divider after the period has already latched its length and before the next boundary. The stimulus sets the first ratio while the divider is idle and starts it. One cycle after the restart edge it switches the code, then drops the start input partway through a later period. The scoreboard therefore expects one period of the old length, periods of the new length, and a final period that ends in a long high park. It measures every low and high run in half-cycles, so a one-half-cycle error in an odd ratio shows up.

// File: rtl/pclkdiv_pkg.sv
// Shared widths, types and the ratio-code table for the pixel clock divider.
// Assumes ratio codes fit SEL_W bits and the largest ratio fits DIV_W bits.
package pclkdiv_pkg;
    localparam int SEL_W     = 4;
    localparam int DIV_W     = 5;
    localparam int NUM_CODES = 9;
    localparam int FALLBACK  = 4;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [DIV_W-1:0] div_t;

    // Maps a ratio code to its division ratio; unused codes fall back.
    function automatic div_t code_to_ratio(input sel_t code);
        case (code)
            SEL_W'(0): return DIV_W'(3);
            SEL_W'(1): return DIV_W'(4);
            SEL_W'(2): return DIV_W'(5);
            SEL_W'(3): return DIV_W'(6);
            SEL_W'(4): return DIV_W'(8);
            SEL_W'(5): return DIV_W'(10);
            SEL_W'(6): return DIV_W'(12);
            SEL_W'(7): return DIV_W'(16);
            SEL_W'(8): return DIV_W'(20);
            default:   return DIV_W'(FALLBACK);
        endcase
    endfunction
endpackage

// File: rtl/pclkdiv_en_sync.sv
// Start-input conditioning: applies the selected active level, passes the
// result through a STAGES-deep synchronizer and flags its inactive-to-active
// transition with a one-cycle pulse.
// Assumes en_pol is static while the start input may toggle.
module pclkdiv_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    input  logic en_pol,
    output logic en_lvl,
    output logic en_rise
);
    logic              act_raw;
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Active level of the raw input after the polarity choice.
    assign act_raw = en_pol ? en_in : ~en_in;

    // Synchronizer chain plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= act_raw;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign en_lvl  = sync_q[STAGES-1];
    assign en_rise = sync_q[STAGES-1] & ~prev_q;

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !en_rise);
endmodule

// File: rtl/pclkdiv_ratio_reg.sv
// Ratio code decoder: registers the decoded ratio so that the divider reads a
// clean value in the fast-clock domain.
// Assumes mod_sel changes rarely, at control-register pace.
module pclkdiv_ratio_reg
    import pclkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel_code,
    output div_t ratio_q
);
    // Decoded ratio register.
    always_ff @(posedge clk) begin
        if (!rst_n) ratio_q <= DIV_W'(FALLBACK);
        else        ratio_q <= code_to_ratio(sel_code);
    end

    // R2
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_code) >= NUM_CODES) |=> (ratio_q == DIV_W'(FALLBACK)));
endmodule

// File: rtl/pclkdiv_phase.sv
// Divider core: counts fast-clock cycles modulo the latched ratio and forms a
// symmetric output phase. The rising-edge phase register covers even ratios.
// For odd ratios it is ANDed with a falling-edge copy, which moves the rising
// transition half a cycle later. The ratio is latched only at restart or wrap.
// When the start level is gone at a wrap, the core parks with its output high.
// Assumes ratios of at least 3.
module pclkdiv_phase
    import pclkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  div_t ratio_in,
    input  logic en_lvl,
    input  logic en_rise,
    output logic pclk_core
);
    div_t cnt_q, cnt_n;
    div_t div_q, div_n;
    logic run_q, run_n;
    logic hi_p_q, hi_n_q, odd_q;
    logic wrap;

    // Last count of the current period.
    assign wrap = run_q && (cnt_q == div_q - DIV_W'(1));

    // Next-state selection: restart, period boundary, or count.
    always_comb begin
        cnt_n = cnt_q;
        div_n = div_q;
        run_n = run_q;
        if (en_rise) begin
            cnt_n = '0;
            div_n = ratio_in;
            run_n = 1'b1;
        end else if (wrap) begin
            cnt_n = '0;
            div_n = ratio_in;
            run_n = en_lvl;
        end else if (run_q) begin
            cnt_n = cnt_q + DIV_W'(1);
        end
    end

    // Rising-edge state: count, ratio, run flag and the registered phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_q  <= DIV_W'(FALLBACK);
            run_q  <= 1'b0;
            hi_p_q <= 1'b1;
            odd_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            div_q  <= div_n;
            run_q  <= run_n;
            hi_p_q <= !run_n || (cnt_n >= (div_n >> 1));
            odd_q  <= div_n[0];
        end
    end

    // Falling-edge copy of the phase, used to stretch odd ratios by half a cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) hi_n_q <= 1'b1;
        else        hi_n_q <= hi_p_q;
    end

    assign pclk_core = odd_q ? (hi_p_q & hi_n_q) : hi_p_q;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < div_q));

    // R4
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (run_q && !hi_p_q));

    // R5
    park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> hi_p_q);

    // R5
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !en_rise) |=> !run_q);

    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wrap && !en_rise) |=> $stable(div_q));
endmodule

// File: rtl/pclk_divider.sv
// Top level: start-input conditioning, ratio register, divider core and the
// output suppress gate.
// Assumes clk is the fast source clock. All inputs other than en_in are
// quasi-static control bits.
module pclk_divider
    import pclkdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             en_pol,
    input  logic [SEL_W-1:0] mod_sel,
    input  logic             suppress,
    output logic             pclk
);
    logic en_lvl, en_rise;
    div_t ratio_q;
    logic pclk_core;
    logic sup_q;

    pclkdiv_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_in   (en_in),
        .en_pol  (en_pol),
        .en_lvl  (en_lvl),
        .en_rise (en_rise)
    );

    pclkdiv_ratio_reg u_ratio (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_code (mod_sel),
        .ratio_q  (ratio_q)
    );

    pclkdiv_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_in  (ratio_q),
        .en_lvl    (en_lvl),
        .en_rise   (en_rise),
        .pclk_core (pclk_core)
    );

    // Registered suppress control.
    always_ff @(posedge clk) begin
        if (!rst_n) sup_q <= 1'b0;
        else        sup_q <= suppress;
    end

    assign pclk = pclk_core | sup_q;

    // R7
    sup_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |=> sup_q);
endmodule

// File: tb/sim_pclk_divider.sv
module sim_pclk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_in = 1'b0;
    logic       en_pol = 1'b1;
    logic [3:0] mod_sel = 4'd1;
    logic       suppress = 1'b0;
    logic       pclk;

    int checks = 0;
    int errors = 0;

    localparam int PARK_HALVES = 41;

    typedef struct {
        int    low_h;
        int    high_h;   // 0 means park (long high)
        string req;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    pclk_divider u0 (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .en_pol(en_pol),
        .mod_sel(mod_sel), .suppress(suppress), .pclk(pclk)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic act_level(input logic active);
        return en_pol ? active : ~active;
    endfunction

    // Driver: pushes the expected periods, then starts and stops the divider.
    task automatic burst(input logic [3:0] sa, input int na,
                         input logic [3:0] sb, input int nb,
                         input int m, input string req);
        int j;
        @(negedge clk) mod_sel = sa;
        repeat (3) @(negedge clk);
        exp_q.push_back('{na, na, req});
        for (int k = 2; k < m; k++) exp_q.push_back('{nb, nb, req});
        exp_q.push_back('{nb, 0, "R5"});
        en_in = act_level(1'b1);
        @(posedge clk);               // E0
        @(posedge clk);               // E1
        #2 check(pclk == 1'b1, "R4", "pclk after E1", int'(pclk), 1);
        @(posedge clk);               // E2
        #2 check(pclk == 1'b0, "R4", "pclk after E2", int'(pclk), 0);
        if (sb != sa) begin
            @(negedge clk) mod_sel = sb;
        end
        j = 2 + na + (m - 2) * nb;
        repeat (j - 3) @(posedge clk);
        @(negedge clk) en_in = act_level(1'b0);
        repeat (2 * nb + 30) @(negedge clk);
        check(pclk == 1'b1, "R5", "parked pclk", int'(pclk), 1);
        check(exp_q.size() == 0, req, "periods left unmatched", exp_q.size(), 0);
    endtask

    // Monitor: measures low/high runs in half-cycles and compares them.
    initial begin
        logic lvl, lvl_prev, have_low;
        int   run, low_len;
        item_t it;
        wait (rst_n === 1'b1);
        @(posedge clk or negedge clk); #1;
        lvl_prev = pclk; run = 1; have_low = 1'b0; low_len = 0;
        forever begin
            @(posedge clk or negedge clk); #1;
            lvl = pclk;
            if (lvl == lvl_prev) begin
                run++;
                if (lvl && have_low && run == PARK_HALVES) begin
                    have_low = 1'b0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5", "unexpected park", low_len, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(it.high_h == 0, it.req, "park where period expected", PARK_HALVES, it.high_h);
                        check(low_len == it.low_h, it.req, "last low halves", low_len, it.low_h);
                    end
                end
            end else begin
                if (!lvl_prev) begin
                    low_len = run; have_low = 1'b1;
                end else if (have_low) begin
                    have_low = 1'b0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected period", run, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(low_len == it.low_h, it.req, "low halves", low_len, it.low_h);
                        check(run == it.high_h, it.req, "high halves", run, it.high_h);
                    end
                end
                run = 1; lvl_prev = lvl;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        repeat (4) @(negedge clk);
        #1 check(pclk == 1'b1, "R9", "pclk in reset", int'(pclk), 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(pclk == 1'b1, "R9", "idle pclk after reset", int'(pclk), 1);

        burst(4'd1, 4,  4'd1, 4,  4, "R1");
        burst(4'd0, 3,  4'd0, 3,  4, "R3");
        burst(4'd2, 5,  4'd2, 5,  3, "R3");
        burst(4'd3, 6,  4'd3, 6,  3, "R1");
        burst(4'd4, 8,  4'd4, 8,  2, "R1");
        burst(4'd5, 10, 4'd5, 10, 2, "R1");
        burst(4'd6, 12, 4'd6, 12, 2, "R1");
        burst(4'd7, 16, 4'd7, 16, 2, "R1");
        burst(4'd8, 20, 4'd8, 20, 2, "R1");
        burst(4'd12, 4, 4'd12, 4, 3, "R2");
        burst(4'd15, 4, 4'd15, 4, 2, "R2");
        burst(4'd4, 8,  4'd7, 16, 3, "R8");
        burst(4'd2, 5,  4'd6, 12, 3, "R8");
        burst(4'd5, 10, 4'd0, 3,  4, "R8");

        // R6: active-low start input; holding it high must not start anything.
        @(negedge clk) begin en_pol = 1'b0; en_in = 1'b1; end
        bad = 0;
        repeat (60) begin @(negedge clk); if (pclk !== 1'b1) bad++; end
        check(bad == 0, "R6", "low samples with inactive-high input", bad, 0);
        burst(4'd3, 6, 4'd3, 6, 3, "R6");
        burst(4'd2, 5, 4'd2, 5, 2, "R6");

        // R7: suppress holds the output high through a whole burst.
        @(negedge clk) begin en_pol = 1'b1; en_in = 1'b0; end
        @(negedge clk) suppress = 1'b1;
        repeat (3) @(negedge clk);
        en_in = 1'b1;
        bad = 0;
        for (int h = 0; h < 120; h++) begin
            @(posedge clk or negedge clk); #1;
            if (pclk !== 1'b1) bad++;
        end
        check(bad == 0, "R7", "low halves while suppressed", bad, 0);
        @(negedge clk) en_in = 1'b0;
        repeat (60) @(negedge clk);
        suppress = 1'b0;
        repeat (10) @(negedge clk);
        check(pclk == 1'b1, "R7", "parked after suppress release", int'(pclk), 1);
        check(exp_q.size() == 0, "R7", "queue after suppress", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule